// File: doc/BRIEF.md
# Packed Signed Multiply-High with Rounding

This block is a SIMD fixed-point multiplier. It treats each of its two operand vectors as a row of signed 16-bit lanes. It multiplies lane i of one vector by lane i of the other and scales each 32-bit product back to a 16-bit Q15-style result, rounding to nearest. There is no saturation. The vector is either 64 bits wide (four lanes) or 128 bits wide (eight lanes), and a mode input selects the width for each operation.

The datapath has two register stages. The first stage captures the lane products. The second stage cuts each product down to its upper 18 bits, adds one at the lowest of those bits, and keeps the 16 bits just below the top bit. A valid flag travels alongside the data, so one operation can enter every cycle and its answer appears two cycles later. The result register keeps its last value until a new operation completes. The mode travels with the data through two states: a narrow state (`wide_mode` = 0, four lanes) and a wide state (`wide_mode` = 1, eight lanes).

Top module: `pmhr_simd`

## Requirements
- R1: For each active lane, the result is bits [16:1] of (P[31:14] + 1), where P is the signed 32-bit product of the two 16-bit lane inputs. Lane i occupies bits [16i+15:16i] of every vector.
- R2: No lane saturates. With both inputs equal to 0x8000 (-32768), the lane result is 0x8000.
- R3: When `wide_mode` is 1, all eight lanes are computed.
- R4: When `wide_mode` is 0, lanes 0 to 3 are computed and `result[127:64]` is zero, whatever the upper operand bits hold.
- R5: `out_valid` is high exactly two clock cycles after the cycle in which `in_valid` was sampled high, and at no other time.
- R6: While reset is held, and until the first operation completes, `out_valid` is 0 and `result` is all zeros.
- R7: `result` changes only in a cycle in which `out_valid` is asserted. Otherwise it holds the last completed answer.
- R8: A new operation can be accepted on every cycle. Back-to-back operations each return their own answer in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| wide_mode | input | 1 | 1 selects eight lanes (128-bit), 0 selects four lanes (64-bit) |
| opa | input | 128 | First operand vector, eight signed 16-bit lanes |
| opb | input | 128 | Second operand vector, eight signed 16-bit lanes |
| out_valid | output | 1 | The result holds a new answer this cycle |
| result | output | 128 | Rounded high products, one per lane |

## Verification
The assertions assume that reset is held for at least one clock edge before the first operation. They also assume that `in_valid` and `wide_mode` are known values at every sampled edge; the bench drives both on falling edges and never leaves them undefined. The lane-rounding assertion assumes the operand lanes hold defined two's-complement values. The bench sweeps a corner set of values that includes both extremes, ±1 and the powers of two that sit on rounding boundaries, and it fills unused upper lanes in narrow mode with random data so that any leakage shows.

// File: rtl/pmhr_pkg.sv
package pmhr_pkg;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } width_mode_e;

endpackage

// File: rtl/pmhr_lane_mul.sv
module pmhr_lane_mul #(
    parameter int LANE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic signed [LANE_W-1:0]     a,
    input  logic signed [LANE_W-1:0]     b,
    output logic signed [2*LANE_W-1:0]   prod
);

    logic signed [2*LANE_W-1:0] prod_d;

    always_comb begin
        prod_d = a * b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else if (load) begin
            prod <= prod_d;
        end
    end

endmodule

// File: rtl/pmhr_lane_round.sv
module pmhr_lane_round #(
    parameter int LANE_W = 16
) (
    input  logic signed [2*LANE_W-1:0] prod,
    output logic        [LANE_W-1:0]   rnd
);

    localparam int PROD_W  = 2 * LANE_W;
    localparam int TRUNC_W = LANE_W + 2;

    logic [TRUNC_W-1:0] trunc;
    logic [TRUNC_W-1:0] bumped;

    always_comb begin
        trunc  = prod[PROD_W-1:PROD_W-TRUNC_W];
        bumped = trunc + {{(TRUNC_W-1){1'b0}}, 1'b1};
        rnd    = bumped[LANE_W:1];
    end

    // Square of the most negative input must wrap, not clip
    always_comb begin
        if (prod == (PROD_W'(1) <<< (PROD_W - 2))) begin
            AST_MIN_SQUARE_WRAPS: assert (rnd == (LANE_W'(1) << (LANE_W - 1))); // R2
        end
    end

endmodule

// File: rtl/pmhr_valid_pipe.sv
module pmhr_valid_pipe
    import pmhr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  width_mode_e in_mode,
    output logic        v1,
    output width_mode_e mode1,
    output logic        v2,
    output width_mode_e mode2
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            mode1 <= MODE_NARROW;
            v2    <= 1'b0;
            mode2 <= MODE_NARROW;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            if (in_valid) begin
                mode1 <= in_mode;
            end
            if (v1) begin
                mode2 <= mode1;
            end
        end
    end

    AST_STAGE1_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v1 == $past(in_valid))); // R5

    AST_STAGE2_FOLLOWS_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v2 == $past(v1))); // R5

endmodule

// File: rtl/pmhr_simd.sv
module pmhr_simd
    import pmhr_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      wide_mode,
    input  logic [LANE_W*LANES-1:0]   opa,
    input  logic [LANE_W*LANES-1:0]   opb,
    output logic                      out_valid,
    output logic [LANE_W*LANES-1:0]   result
);

    localparam int VEC_W  = LANE_W * LANES;
    localparam int NARROW = LANES / 2;
    localparam int HALF_W = LANE_W * NARROW;
    localparam int PROD_W = 2 * LANE_W;

    width_mode_e               in_mode;
    logic                      v1;
    width_mode_e               mode1;
    width_mode_e               mode2;
    logic [VEC_W-1:0]          next_result;
    logic [VEC_W-1:0]          result_q;
    logic signed [PROD_W-1:0]  prod   [LANES];
    logic [LANE_W-1:0]         rnd    [LANES];
    logic [LANES-1:0]          in_on;
    logic [LANES-1:0]          out_on;

    assign in_mode = width_mode_e'(wide_mode);

    pmhr_valid_pipe u_vpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_mode  (in_mode),
        .v1       (v1),
        .mode1    (mode1),
        .v2       (out_valid),
        .mode2    (mode2)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < NARROW) begin : g_low
            assign in_on[i]  = 1'b1;
            assign out_on[i] = 1'b1;
        end else begin : g_high
            assign in_on[i]  = (in_mode == MODE_WIDE);
            assign out_on[i] = (mode1 == MODE_WIDE);
        end

        pmhr_lane_mul #(.LANE_W(LANE_W)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (in_valid && in_on[i]),
            .a     (opa[i*LANE_W +: LANE_W]),
            .b     (opb[i*LANE_W +: LANE_W]),
            .prod  (prod[i])
        );

        pmhr_lane_round #(.LANE_W(LANE_W)) u_rnd (
            .prod (prod[i]),
            .rnd  (rnd[i])
        );

        assign next_result[i*LANE_W +: LANE_W] = out_on[i] ? rnd[i] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (v1) begin
            result_q <= next_result;
        end
    end

    assign result = result_q;

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode2 == MODE_NARROW) |-> (result[VEC_W-1:HALF_W] == '0)); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !v1 |=> $stable(result)); // R7

endmodule

// File: tb/pmhr_simd_test.sv
module pmhr_simd_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         wide_mode = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         out_valid;
    logic [127:0] result;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic         hv [2];
    logic [127:0] hd [2];
    string        htag [2];
    logic [127:0] last_res;

    logic signed [15:0] vals [16];

    always #5 clk = ~clk;

    pmhr_simd uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wide_mode (wide_mode),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [15:0] ref_lane(logic signed [15:0] a, logic signed [15:0] b);
        longint p;
        longint q;
        p = longint'(a) * longint'(b);
        q = ((p >>> 14) + 1) >>> 1;
        return q[15:0];
    endfunction

    function automatic logic [127:0] ref_vec(logic [127:0] a, logic [127:0] b, logic m);
        logic [127:0] r;
        r = '0;
        for (int l = 0; l < 8; l++) begin
            if (m || l < 4) begin
                r[l*16 +: 16] = ref_lane(a[l*16 +: 16], b[l*16 +: 16]);
            end
        end
        return r;
    endfunction

    task automatic check_out(input logic ev, input logic [127:0] ed, input string tag);
        nchk++;
        if (ev) begin
            if (out_valid !== 1'b1 || result !== ed) begin
                nfail++;
                $display("FAIL %s: out_valid=%b result=%h expected out_valid=1 result=%h",
                         tag, out_valid, result, ed);
            end
            last_res = ed;
        end else begin
            if (out_valid !== 1'b0 || result !== last_res) begin
                nfail++;
                $display("FAIL %s: out_valid=%b result=%h expected out_valid=0 result=%h",
                         tag, out_valid, result, last_res);
            end
        end
    endtask

    task automatic step(input logic v, input logic m, input logic [127:0] a,
                        input logic [127:0] b, input string tag);
        @(negedge clk);
        check_out(hv[1], hd[1], htag[1]);
        hv[1]   = hv[0];
        hd[1]   = hd[0];
        htag[1] = htag[0];
        in_valid  = v;
        wide_mode = m;
        opa = a;
        opb = b;
        hv[0]   = v;
        hd[0]   = v ? ref_vec(a, b, m) : '0;
        htag[0] = v ? tag : "R5/R7 idle";
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        vals = '{16'sh0000, 16'sh0001, -16'sh0001, 16'sh0002, -16'sh0002, 16'sh7FFF,
                 16'sh8000, 16'sh8001, 16'sh4000, -16'sh4000, 16'sh2000, 16'sh3039,
                 -16'sh3039, 16'sh00FF, 16'sh7FFE, 16'sh0003};
        hv[0] = 0; hv[1] = 0;
        hd[0] = '0; hd[1] = '0;
        htag[0] = "R6"; htag[1] = "R6";
        last_res = '0;

        repeat (3) @(negedge clk);
        // R6: reset state held during reset
        nchk++;
        if (out_valid !== 1'b0 || result !== '0) begin
            nfail++;
            $display("FAIL R6: out_valid=%b result=%h expected out_valid=0 result=0", out_valid, result);
        end
        rst_n = 1'b1;

        // R6: after release, outputs stay at reset values while idle
        step(0, 0, '0, '0, "R6");
        step(0, 0, '0, '0, "R6");

        // R5: isolated operation, then idle to observe exact latency
        step(1, 1, {8{16'h4000}}, {8{16'h4000}}, "R5");
        for (int k = 0; k < 4; k++) step(0, 1, rnd128(), rnd128(), "R5");

        // R2: most negative squared wraps to 0x8000 in every lane
        step(1, 1, {8{16'h8000}}, {8{16'h8000}}, "R2");
        step(0, 0, '0, '0, "R2");
        step(0, 0, '0, '0, "R2");

        // R1/R3: all 256 corner pairs, eight lanes per operation
        for (int k = 0; k < 32; k++) begin
            logic [127:0] a;
            logic [127:0] b;
            for (int l = 0; l < 8; l++) begin
                a[l*16 +: 16] = vals[(8*k + l) / 16];
                b[l*16 +: 16] = vals[(8*k + l) % 16];
            end
            step(1, 1, a, b, "R1/R3 wide sweep");
        end

        // R4: corner pairs in four lanes, upper operand halves random
        for (int k = 0; k < 64; k++) begin
            logic [127:0] a;
            logic [127:0] b;
            a = rnd128();
            b = rnd128();
            for (int l = 0; l < 4; l++) begin
                a[l*16 +: 16] = vals[(4*k + l) / 16];
                b[l*16 +: 16] = vals[(4*k + l) % 16];
            end
            step(1, 0, a, b, "R4 narrow sweep");
        end

        // R8: random back-to-back stream with occasional gaps and mode changes
        for (int k = 0; k < 3000; k++) begin
            logic v;
            v = ($urandom() % 5) != 0;
            step(v, 1'($urandom()), rnd128(), rnd128(), "R1/R8 stream");
        end

        for (int k = 0; k < 4; k++) step(0, 0, '0, '0, "R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R5: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule